// File: doc/BRIEF.md
# DTMF Guard-Time Steering and Output Latch

This block sits behind a tone-pair classifier in a touch-tone receiver. The classifier supplies an early detect flag and a 4-bit key code. In place of an external resistor-capacitor timing network, this block uses digital counters to time two guard intervals. The first is a tone-present interval, which must pass before a key is registered. The second is a tone-absent interval, which must pass before the receiver is re-armed for the next key.

When the present guard has been met, the key code is captured into a holding register. A programmed number of clock cycles later, the registered flag is raised, so the data is always stable before the flag. A gap in the tone that is shorter than the absent guard is bridged: the tone stays registered and the held code does not change. The held code stays valid until the next key is accepted. The output bus is split into a data vector and a drive enable, for a pad or a shared bus. The holding register keeps updating while the drive is off.

Both guard lengths come in on configuration ports, in units of milliseconds. A prescaler turns the system clock into millisecond ticks, and the prescaler restarts each time a guard interval starts. With `CLKS_PER_MS` = C, a present guard of P and an absent guard of A, the timing is as follows. Acceptance needs the detect flag high on P·C+1 consecutive rising edges. Release needs the flag low on A·C+1 consecutive rising edges.

Top module: `dtmf_steer`

## Requirements
- R1: After reset the held code is 0000, `key_valid` is low and the guard logic waits in its idle, no-tone state.
- R2: From idle, if `tone_det` is high on P·C+1 consecutive rising edges, `key_in` is captured into the held code on the last of those edges. If the flag falls before that, the held code and `key_valid` stay unchanged. A configured guard of zero acts as one millisecond.
- R3: `key_valid` rises exactly `SETTLE_CYC` clock cycles after the held code is updated. The held code is stable on the edge where `key_valid` rises.
- R4: Once a key is registered, `key_valid` stays high and the held code is not reloaded for as long as `tone_det` stays high.
- R5: After a registered key, `tone_det` low on A·C+1 consecutive edges drops `key_valid` and re-arms acceptance. `key_valid` never falls while the detect flag is high.
- R6: A dropout of `tone_det` lasting at most A·C edges leaves `key_valid` high and the held code unchanged, even if `key_in` changes meanwhile.
- R7: The held code changes only when a new key is accepted from idle. Otherwise it keeps the last accepted code.
- R8: `bus_oe` follows `out_en`. `bus_q` carries the held code when `out_en` is 1 and all zeros when it is 0. Capture into the held code proceeds whatever the value of `out_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tone_det | input | 1 | Early detect flag from the classifier, synchronous to clk |
| key_in | input | 4 | Key code from the classifier |
| out_en | input | 1 | Output bus enable |
| cfg_present_ms | input | GUARD_W | Tone-present guard in milliseconds |
| cfg_absent_ms | input | GUARD_W | Tone-absent guard in milliseconds |
| bus_q | output | 4 | Held key code, zero while not enabled |
| bus_oe | output | 1 | Drive enable for the data bus |
| key_valid | output | 1 | Delayed registered-key flag |

## Verification
The assertions assume that `tone_det` and `key_in` are already synchronous to `clk`. They also assume that the guard configuration does not change while a guard interval is being timed. The stimulus changes inputs only at falling edges and reprograms the guard lengths only after a long idle gap. Tone and gap lengths are drawn at random from classes that lie clearly on one side of each threshold, or they are placed exactly on the P·C and P·C+1 boundaries. This makes the expected outcome a function of the programmed lengths alone.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;
   typedef enum logic [2:0] {
      GS_IDLE   = 3'd0,
      GS_ACQ    = 3'd1,
      GS_SETTLE = 3'd2,
      GS_HELD   = 3'd3,
      GS_REL    = 3'd4
   } guard_state_t;
endpackage

// File: rtl/dtmf_ms_prescaler.sv
module dtmf_ms_prescaler #(
   parameter int CLKS_PER_MS = 200000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   output logic tick
);
   generate
      if (CLKS_PER_MS == 1) begin : g_direct
         assign tick = run;
      end else begin : g_count
         localparam int CW = $clog2(CLKS_PER_MS);
         localparam logic [CW-1:0] LAST = CW'(CLKS_PER_MS - 1);
         logic [CW-1:0] cnt;
         assign tick = run && (cnt == LAST);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       cnt <= '0;
            else if (restart) cnt <= '0;
            else if (run)     cnt <= tick ? '0 : cnt + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/dtmf_guard_fsm.sv
module dtmf_guard_fsm
   import dtmf_steer_pkg::*;
#(
   parameter int GUARD_W    = 8,
   parameter int SETTLE_CYC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tone_det,
   input  logic               tick,
   input  logic [GUARD_W-1:0] present_ms,
   input  logic [GUARD_W-1:0] absent_ms,
   output logic               restart,
   output logic               run,
   output logic               load,
   output logic               valid
);
   localparam int SW = $clog2(SETTLE_CYC + 1);
   localparam logic [SW-1:0] SLAST = SW'(SETTLE_CYC - 1);

   guard_state_t       state;
   logic [GUARD_W-1:0] ms_cnt;
   logic [SW-1:0]      set_cnt;
   logic [GUARD_W:0]   ms_next;
   logic               pres_done, abs_done, rel_fire;

   assign ms_next   = {1'b0, ms_cnt} + 1'b1;
   assign pres_done = ms_next >= {1'b0, present_ms};
   assign abs_done  = ms_next >= {1'b0, absent_ms};

   assign restart  = ((state == GS_IDLE) && tone_det) || ((state == GS_HELD) && !tone_det);
   assign run      = ((state == GS_ACQ) && tone_det) || ((state == GS_REL) && !tone_det);
   assign load     = (state == GS_ACQ) && tone_det && tick && pres_done;
   assign rel_fire = (state == GS_REL) && !tone_det && tick && abs_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= GS_IDLE;
         ms_cnt  <= '0;
         set_cnt <= '0;
         valid   <= 1'b0;
      end else begin
         unique case (state)
            GS_IDLE: if (tone_det) begin
               state  <= GS_ACQ;
               ms_cnt <= '0;
            end
            GS_ACQ: begin
               if (!tone_det) begin
                  state <= GS_IDLE;
               end else if (load) begin
                  state   <= GS_SETTLE;
                  set_cnt <= '0;
               end else if (tick) begin
                  ms_cnt <= ms_cnt + 1'b1;
               end
            end
            GS_SETTLE: begin
               if (set_cnt == SLAST) begin
                  state <= GS_HELD;
                  valid <= 1'b1;
               end else begin
                  set_cnt <= set_cnt + 1'b1;
               end
            end
            GS_HELD: if (!tone_det) begin
               state  <= GS_REL;
               ms_cnt <= '0;
            end
            GS_REL: begin
               if (tone_det) begin
                  state <= GS_HELD;
               end else if (rel_fire) begin
                  state <= GS_IDLE;
                  valid <= 1'b0;
               end else if (tick) begin
                  ms_cnt <= ms_cnt + 1'b1;
               end
            end
            default: state <= GS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dtmf_code_latch.sv
module dtmf_code_latch #(
   parameter int CODE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CODE_W-1:0] din,
   input  logic              oe,
   output logic [CODE_W-1:0] held,
   output logic [CODE_W-1:0] q,
   output logic              q_oe
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    held <= '0;
      else if (load) held <= din;
   end
   assign q    = oe ? held : '0;
   assign q_oe = oe;
endmodule

// File: rtl/dtmf_steer.sv
module dtmf_steer #(
   parameter int CLKS_PER_MS = 200000,
   parameter int GUARD_W     = 8,
   parameter int SETTLE_CYC  = 4,
   parameter int CODE_W      = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tone_det,
   input  logic [CODE_W-1:0]  key_in,
   input  logic               out_en,
   input  logic [GUARD_W-1:0] cfg_present_ms,
   input  logic [GUARD_W-1:0] cfg_absent_ms,
   output logic [CODE_W-1:0]  bus_q,
   output logic               bus_oe,
   output logic               key_valid
);
   generate
      if (CLKS_PER_MS < 1) begin : g_bad_clks
         $error("CLKS_PER_MS must be at least 1");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("SETTLE_CYC must be at least 1");
      end
      if (GUARD_W < 1 || CODE_W < 1) begin : g_bad_width
         $error("GUARD_W and CODE_W must be positive");
      end
   endgenerate

   logic              restart, run, tick, load;
   logic [CODE_W-1:0] code_q;

   dtmf_ms_prescaler #(.CLKS_PER_MS(CLKS_PER_MS)) u_presc (
      .clk(clk), .rst_n(rst_n), .restart(restart), .run(run), .tick(tick)
   );

   dtmf_guard_fsm #(.GUARD_W(GUARD_W), .SETTLE_CYC(SETTLE_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .tone_det(tone_det), .tick(tick),
      .present_ms(cfg_present_ms), .absent_ms(cfg_absent_ms),
      .restart(restart), .run(run), .load(load), .valid(key_valid)
   );

   dtmf_code_latch #(.CODE_W(CODE_W)) u_latch (
      .clk(clk), .rst_n(rst_n), .load(load), .din(key_in), .oe(out_en),
      .held(code_q), .q(bus_q), .q_oe(bus_oe)
   );
endmodule

// File: rtl/dtmf_steer_chk.sv
module dtmf_steer_chk #(
   parameter int CODE_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tone_det,
   input logic              out_en,
   input logic              key_valid,
   input logic              bus_oe,
   input logic [CODE_W-1:0] bus_q,
   input logic [CODE_W-1:0] code_q
);
   // R3
   data_before_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(key_valid) |-> $stable(code_q));

   // R4
   hold_while_tone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (key_valid && tone_det) |=> key_valid);

   // R5
   release_on_absence_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(key_valid) |-> !$past(tone_det));

   // R7
   capture_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code_q != $past(code_q)) |-> (!key_valid && !$past(key_valid) && $past(tone_det)));

   // R8
   bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |-> (bus_q == '0 && !bus_oe));
endmodule

bind dtmf_steer dtmf_steer_chk #(.CODE_W(CODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tone_det(tone_det), .out_en(out_en),
   .key_valid(key_valid), .bus_oe(bus_oe), .bus_q(bus_q), .code_q(code_q)
);

// File: tb/dtmf_steer_bench.sv
`timescale 1ns/1ps
module dtmf_steer_bench;
   localparam int C  = 4;
   localparam int S  = 3;
   localparam int GW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tone_det = 1'b0;
   logic [3:0]    key_in = '0;
   logic          out_en = 1'b1;
   logic [GW-1:0] cfg_p = 8'd3;
   logic [GW-1:0] cfg_a = 8'd2;
   logic [3:0]    bus_q;
   logic          bus_oe;
   logic          key_valid;

   int   n_cmp = 0;
   int   n_bad = 0;
   bit   ended = 0;
   logic [3:0] exp_code = '0;

   always #2.5 clk = ~clk;

   dtmf_steer #(.CLKS_PER_MS(C), .GUARD_W(GW), .SETTLE_CYC(S), .CODE_W(4)) u_dtmf_steer (
      .clk(clk), .rst_n(rst_n), .tone_det(tone_det), .key_in(key_in), .out_en(out_en),
      .cfg_present_ms(cfg_p), .cfg_absent_ms(cfg_a),
      .bus_q(bus_q), .bus_oe(bus_oe), .key_valid(key_valid)
   );

   function automatic int acc_len(input logic [GW-1:0] p);
      return ((p == 0) ? 1 : int'(p)) * C + 1;
   endfunction
   function automatic int rel_len(input logic [GW-1:0] a);
      return ((a == 0) ? 1 : int'(a)) * C + 1;
   endfunction
   function automatic logic [3:0] exp_bus(input logic oe, input logic [3:0] c);
      return oe ? c : 4'h0;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic tone(input logic [3:0] k, input int n);
      tone_det = 1'b1;
      key_in   = k;
      cycles(n);
      tone_det = 1'b0;
   endtask

   task automatic idle_gap();
      cycles(S + rel_len(cfg_a) + 6);
   endtask

   task automatic check_bus(input string req);
      chk(req, int'(bus_oe), int'(out_en));
      chk(req, int'(bus_q), int'(exp_bus(out_en, exp_code)));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         ended = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      cycles(3);
      // R1 reset state
      chk("R1", int'(bus_q), 0);
      chk("R1", int'(key_valid), 0);
      rst_n = 1'b1;
      cycles(2);
      chk("R1", int'(key_valid), 0);

      // R2 exact boundary: P*C edges rejected
      tone(4'h5, acc_len(cfg_p) - 1);
      chk("R2", int'(bus_q), 0);
      chk("R2", int'(key_valid), 0);
      idle_gap();
      chk("R7", int'(bus_q), 0);

      // R2 exact boundary: P*C+1 edges accepted, R3 settle timing
      tone(4'h9, acc_len(cfg_p));
      exp_code = 4'h9;
      chk("R2", int'(bus_q), 9);
      chk("R3", int'(key_valid), 0);
      cycles(S - 1);
      chk("R3", int'(key_valid), 0);
      cycles(1);
      chk("R3", int'(key_valid), 1);
      idle_gap();
      chk("R5", int'(key_valid), 0);
      check_bus("R7");

      // R4 long tone held; R6 short dropout bridged with changed key_in
      tone(4'h3, acc_len(cfg_p) + S + 10);
      exp_code = 4'h3;
      chk("R4", int'(key_valid), 1);
      key_in = 4'hC;
      cycles(rel_len(cfg_a) - 1);
      chk("R6", int'(key_valid), 1);
      tone(4'hE, 20);
      chk("R4", int'(key_valid), 1);
      chk("R6", int'(bus_q), 3);

      // R5 exact release boundary
      cycles(rel_len(cfg_a) - 1);
      chk("R5", int'(key_valid), 1);
      cycles(1);
      chk("R5", int'(key_valid), 0);
      idle_gap();

      // R8 capture while bus disabled
      out_en = 1'b0;
      tone(4'hA, acc_len(cfg_p) + S + 2);
      exp_code = 4'hA;
      chk("R8", int'(bus_q), 0);
      chk("R8", int'(bus_oe), 0);
      idle_gap();
      out_en = 1'b1;
      cycles(1);
      chk("R8", int'(bus_q), 10);

      // R2 zero guard acts as one millisecond
      cfg_p = 8'd0;
      cycles(2);
      tone(4'h7, C);
      chk("R2", int'(bus_q), 10);
      idle_gap();
      tone(4'h7, C + 1);
      exp_code = 4'h7;
      chk("R2", int'(bus_q), 7);
      idle_gap();

      // constrained random mix
      void'($urandom(32'h1d7a5));
      for (int it = 0; it < 40; it++) begin
         int cls, n;
         logic [3:0] k;
         cfg_p = GW'(2 + ($urandom % 4));
         cfg_a = GW'(2 + ($urandom % 4));
         out_en = ($urandom % 4) != 0;
         k = 4'($urandom);
         cls = $urandom % 3;
         cycles(2);
         if (cls == 0) begin
            n = 1 + ($urandom % (acc_len(cfg_p) - 1));
            tone(k, n);
            chk("R2", int'(key_valid), 0);
         end else begin
            n = acc_len(cfg_p) + S + 2 + ($urandom % 16);
            tone(k, n);
            exp_code = k;
            chk("R4", int'(key_valid), 1);
            if (cls == 2) begin
               cycles(1 + ($urandom % (rel_len(cfg_a) - 1)));
               tone(4'(~k), 5);
               chk("R6", int'(key_valid), 1);
            end
         end
         idle_gap();
         chk("R5", int'(key_valid), 0);
         check_bus("R7");
      end

      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule